// File: doc/BRIEF.md
# 1-Wire Reset and Presence Detector

This block runs the reset sequence of a 1-Wire bus master. On a start strobe it pulls the open-drain line low for a fixed reset time. It then releases the line and watches it for a fixed recovery time. During that watch it checks two things. First, the line must actually rise once the pullup alone drives it. Second, it looks for a slave answering with a presence pulse. When the watch ends it raises a one-clock completion pulse and latches a two-bit result.

Timing is counted in microseconds from an external one-microsecond tick, so the system clock can be any rate well above 1 MHz. A speed input selects regular or overdrive timing, and its value is captured when the sequence starts. The raw line is passed through a two-flop synchronizer before any decision is made. The enclosing master uses the result to decide whether to go on to ROM commands. The result is refreshed on every sequence, including sequences that end in an error.

Top module: `onewire_reset_presence`

## Requirements
- R1: A `start` pulse while `busy` is low makes `pull_low` and `busy` go high on the next clock.
- R2: `pull_low` stays high for exactly 500 `us_tick` pulses at regular speed and 60 at overdrive. The speed is the value of `overdrive` when `start` is accepted (1 = overdrive).
- R3: After release, `pull_low` stays low and `busy` stays high for exactly 500 ticks at regular speed and 50 at overdrive. `done` then pulses for one clock while `busy` drops to low.
- R4: Ticks after release are numbered from 1. If the synchronized line is low at tick 5 (regular) or tick 1 (overdrive), the result is bus error, 2'b11. This takes priority over presence. A low that ends before that tick is not an error.
- R5: Otherwise, the result is present (2'b00) if the synchronized line is low at any tick in 15..75 (regular) or 2..10 (overdrive). If not, the result is no slave (2'b01). A low seen only after the window is ignored.
- R6: `status` resets to 2'b01. It changes only in the cycle where `done` is high, it is refreshed on every completed sequence, and it never takes the value 2'b10.
- R7: While `busy` is high, `start` pulses and changes on `overdrive` have no effect on timing or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begin a reset sequence (accepted only when idle) |
| overdrive | input | 1 | Speed select captured at start: 1 = overdrive, 0 = regular |
| us_tick | input | 1 | One-clock strobe once per microsecond |
| line_in | input | 1 | Raw level of the bus line |
| pull_low | output | 1 | Open-drain enable: 1 drives the line low |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-clock pulse at the end of a sequence |
| status | output | 2 | Latched result: 00 present, 01 no slave, 11 bus error |

## Verification
The assertions assume that `start` is a clean synchronous strobe and that `us_tick` is at most one clock wide. They also assume reset is held for a few clocks before the first sequence. The stimulus spaces ticks four clocks apart, which leaves room for the two-clock synchronizer delay. It derives the line level from the design's own `pull_low` together with a modelled slave, so the line is never driven high while the master holds it low. Slave pulses are placed relative to the released edge. Some sit exactly on the window limits and some sit one tick outside them.

// File: rtl/owrp_pkg.sv
package owrp_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    RES_PRESENT = 2'b00,
    RES_ABSENT  = 2'b01,
    RES_BUSERR  = 2'b11
  } result_e;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/owrp_line_sync.sv
module owrp_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= 1'b1;
        else        chain_q <= raw_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], raw_in};
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/owrp_us_timer.sv
module owrp_us_timer #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);

  logic [W-1:0] count_q, count_nx;

  always_comb begin
    count_nx = count_q;
    if (clr)      count_nx = '0;
    else if (inc) count_nx = count_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_nx;
  end

  assign count = count_q;

endmodule

// File: rtl/owrp_window_judge.sv
module owrp_window_judge #(
  parameter int W           = 10,
  parameter int REG_RISE    = 5,
  parameter int REG_PD_LO   = 15,
  parameter int REG_PD_HI   = 75,
  parameter int OD_RISE     = 1,
  parameter int OD_PD_LO    = 2,
  parameter int OD_PD_HI    = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         sample,
  input  logic         od,
  input  logic [W-1:0] elapsed,
  input  logic         line_hi,
  output logic         err_nx,
  output logic         pres_nx
);

  localparam logic [W-1:0] RRISE = W'(REG_RISE);
  localparam logic [W-1:0] RLO   = W'(REG_PD_LO);
  localparam logic [W-1:0] RHI   = W'(REG_PD_HI);
  localparam logic [W-1:0] ORISE = W'(OD_RISE);
  localparam logic [W-1:0] OLO   = W'(OD_PD_LO);
  localparam logic [W-1:0] OHI   = W'(OD_PD_HI);

  logic         err_q, pres_q;
  logic [W-1:0] rise_at, win_lo, win_hi;
  logic         in_win;

  always_comb begin
    rise_at = od ? ORISE : RRISE;
    win_lo  = od ? OLO   : RLO;
    win_hi  = od ? OHI   : RHI;
    in_win  = (elapsed >= win_lo) && (elapsed <= win_hi);
  end

  always_comb begin
    err_nx  = err_q;
    pres_nx = pres_q;
    if (clr) begin
      err_nx  = 1'b0;
      pres_nx = 1'b0;
    end else if (sample && !line_hi) begin
      if (elapsed == rise_at) err_nx  = 1'b1;
      if (in_win)             pres_nx = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      pres_q <= 1'b0;
    end else begin
      err_q  <= err_nx;
      pres_q <= pres_nx;
    end
  end

endmodule

// File: rtl/onewire_reset_presence.sv
module onewire_reset_presence
  import owrp_pkg::*;
#(
  parameter int REG_LOW_US      = 500,
  parameter int REG_RISE_US     = 5,
  parameter int REG_PD_FIRST_US = 15,
  parameter int REG_PD_LAST_US  = 75,
  parameter int REG_HIGH_US     = 500,
  parameter int OD_LOW_US       = 60,
  parameter int OD_RISE_US      = 1,
  parameter int OD_PD_FIRST_US  = 2,
  parameter int OD_PD_LAST_US   = 10,
  parameter int OD_HIGH_US      = 50,
  parameter int SYNC_STAGES     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       overdrive,
  input  logic       us_tick,
  input  logic       line_in,
  output logic       pull_low,
  output logic       busy,
  output logic       done,
  output logic [1:0] status
);

  localparam int MAX_US = max_of4(REG_LOW_US, REG_HIGH_US, OD_LOW_US, OD_HIGH_US);
  localparam int CNT_W  = $clog2(MAX_US + 1);
  localparam logic [CNT_W-1:0] REG_LOW_LAST  = CNT_W'(REG_LOW_US - 1);
  localparam logic [CNT_W-1:0] OD_LOW_LAST   = CNT_W'(OD_LOW_US - 1);
  localparam logic [CNT_W-1:0] REG_HIGH_LAST = CNT_W'(REG_HIGH_US - 1);
  localparam logic [CNT_W-1:0] OD_HIGH_LAST  = CNT_W'(OD_HIGH_US - 1);

  phase_e           phase_q, phase_nx;
  result_e          result_q, result_nx;
  logic             od_q, od_nx;
  logic             done_q, done_nx;
  logic             line_hi;
  logic [CNT_W-1:0] cnt, elapsed;
  logic             launch, low_last, high_last, tmr_clr, hi_sample;
  logic             err_nx, pres_nx;

  owrp_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (line_in),
    .sync_out (line_hi)
  );

  owrp_us_timer #(.W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .inc   (us_tick),
    .count (cnt)
  );

  owrp_window_judge #(
    .W         (CNT_W),
    .REG_RISE  (REG_RISE_US),
    .REG_PD_LO (REG_PD_FIRST_US),
    .REG_PD_HI (REG_PD_LAST_US),
    .OD_RISE   (OD_RISE_US),
    .OD_PD_LO  (OD_PD_FIRST_US),
    .OD_PD_HI  (OD_PD_LAST_US)
  ) u_judge (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (launch),
    .sample  (hi_sample),
    .od      (od_q),
    .elapsed (elapsed),
    .line_hi (line_hi),
    .err_nx  (err_nx),
    .pres_nx (pres_nx)
  );

  // Control decode
  always_comb begin
    launch    = (phase_q == PH_IDLE) && start;
    low_last  = (phase_q == PH_LOW) && us_tick &&
                (cnt == (od_q ? OD_LOW_LAST : REG_LOW_LAST));
    high_last = (phase_q == PH_HIGH) && us_tick &&
                (cnt == (od_q ? OD_HIGH_LAST : REG_HIGH_LAST));
    hi_sample = (phase_q == PH_HIGH) && us_tick;
    tmr_clr   = launch || low_last || high_last;
    elapsed   = cnt + CNT_W'(1);
  end

  // Next state
  always_comb begin
    phase_nx  = phase_q;
    od_nx     = od_q;
    done_nx   = 1'b0;
    result_nx = result_q;
    case (phase_q)
      PH_IDLE: begin
        if (launch) begin
          phase_nx = PH_LOW;
          od_nx    = overdrive;
        end
      end
      PH_LOW: begin
        if (low_last) phase_nx = PH_HIGH;
      end
      PH_HIGH: begin
        if (high_last) begin
          phase_nx = PH_IDLE;
          done_nx  = 1'b1;
          if (err_nx)       result_nx = RES_BUSERR;
          else if (pres_nx) result_nx = RES_PRESENT;
          else              result_nx = RES_ABSENT;
        end
      end
      default: phase_nx = PH_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      od_q     <= 1'b0;
      done_q   <= 1'b0;
      result_q <= RES_ABSENT;
    end else begin
      phase_q  <= phase_nx;
      od_q     <= od_nx;
      done_q   <= done_nx;
      result_q <= result_nx;
    end
  end

  assign pull_low = (phase_q == PH_LOW);
  assign busy     = (phase_q != PH_IDLE);
  assign done     = done_q;
  assign status   = result_q;

endmodule

// File: rtl/onewire_reset_presence_chk.sv
module onewire_reset_presence_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       overdrive,
  input logic       us_tick,
  input logic       line_in,
  input logic       pull_low,
  input logic       busy,
  input logic       done,
  input logic [1:0] status
);

  AST_LAUNCH_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (pull_low && busy)); // R1

  AST_RELEASE_STAYS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pull_low) |-> (busy && !done)); // R3

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3

  AST_DONE_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !pull_low)); // R3

  AST_STATUS_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status) |-> done); // R6

  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    status != 2'b10); // R6

  AST_NO_RESTART_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pull_low && start) |=> !pull_low); // R7

endmodule

bind onewire_reset_presence onewire_reset_presence_chk chk_i (.*);

// File: tb/onewire_reset_presence_tb_top.sv
module onewire_reset_presence_tb_top;

  logic       clk;
  logic       rst_n;
  logic       start;
  logic       overdrive;
  logic       us_tick;
  logic       line_in;
  logic       pull_low;
  logic       busy;
  logic       done;
  logic [1:0] status;

  int errors;
  int checks;

  onewire_reset_presence dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .overdrive (overdrive),
    .us_tick   (us_tick),
    .line_in   (line_in),
    .pull_low  (pull_low),
    .busy      (busy),
    .done      (done),
    .status    (status)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Slave scenario controls (relative to the release, in ticks)
  int pd_at, pd_len, stuck_us;
  int div, rel_us;
  bit armed;
  int low_ticks, high_ticks, done_cnt;

  // Reference model state
  int m_state;  // 0 idle, 1 low, 2 high
  int m_cnt, m_status;
  bit m_od, m_err, m_pres, m_done, m_s1, m_s2;

  function automatic int f_low(bit od);   return od ? 60 : 500; endfunction
  function automatic int f_high(bit od);  return od ? 50 : 500; endfunction
  function automatic int f_rise(bit od);  return od ? 1  : 5;   endfunction
  function automatic int f_wlo(bit od);   return od ? 2  : 15;  endfunction
  function automatic int f_whi(bit od);   return od ? 10 : 75;  endfunction

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural model, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_status = 1; m_od = 0;
      m_err = 0; m_pres = 0; m_done = 0; m_s1 = 1; m_s2 = 1;
    end else begin
      bit ls;
      int e;
      ls = m_s2; m_s2 = m_s1; m_s1 = line_in;
      m_done = 0;
      if (m_state == 0) begin
        if (start) begin
          m_state = 1; m_cnt = 0; m_od = overdrive; m_err = 0; m_pres = 0;
        end
      end else if (m_state == 1) begin
        if (us_tick) begin
          if (m_cnt == f_low(m_od) - 1) begin m_state = 2; m_cnt = 0; end
          else m_cnt++;
        end
      end else begin
        if (us_tick) begin
          e = m_cnt + 1;
          if (!ls && e == f_rise(m_od)) m_err = 1;
          if (!ls && e >= f_wlo(m_od) && e <= f_whi(m_od)) m_pres = 1;
          if (m_cnt == f_high(m_od) - 1) begin
            m_state = 0; m_done = 1;
            m_status = m_err ? 3 : (m_pres ? 0 : 1);
          end else m_cnt++;
        end
      end
    end
  end

  // Compare, then drive tick and line, on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1/R2", int'(pull_low), int'(m_state == 1), "pull_low vs model");
      chk("R3/R7", int'(busy), int'(m_state != 0), "busy vs model");
      chk("R3", int'(done), int'(m_done), "done vs model");
      chk("R6", int'(status), m_status, "status vs model");
    end
    div = (div + 1) % 4;
    us_tick = rst_n && (div == 3);
    if (us_tick && pull_low) low_ticks++;
    if (us_tick && busy && !pull_low) high_ticks++;
    if (done) begin done_cnt++; armed = 0; end
    if (pull_low) begin armed = 1; rel_us = 0; end
    else if (armed && us_tick) rel_us++;
    line_in = !(pull_low ||
                (armed && !pull_low &&
                 ((rel_us < stuck_us) || (rel_us >= pd_at && rel_us < pd_at + pd_len))));
  end

  task automatic run(input bit od, input int a, input int l, input int stuck,
                     input int exp_st, input string req, input bit disturb);
    pd_at = a; pd_len = l; stuck_us = stuck;
    low_ticks = 0; high_ticks = 0; done_cnt = 0;
    @(negedge clk);
    start = 1'b1; overdrive = od;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      repeat (150) @(negedge clk);
      start = 1'b1; overdrive = ~od;          // R7: during low phase
      @(negedge clk);
      start = 1'b0;
      repeat (150) @(negedge clk);
      start = 1'b1;                           // R7: during high phase
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    overdrive = od;
    chk(req, int'(status), exp_st, "final status");
    chk("R2", low_ticks, f_low(od), "ticks with line pulled low");
    chk("R3", high_ticks, f_high(od), "ticks in watch phase");
    chk("R3", done_cnt, 1, "done pulses per sequence");
  endtask

  initial begin
    errors = 0; checks = 0;
    rst_n = 1'b0; start = 1'b0; overdrive = 1'b0; us_tick = 1'b0; line_in = 1'b1;
    div = 0; rel_us = 0; armed = 0; pd_at = 100000; pd_len = 0; stuck_us = 0;
    low_ticks = 0; high_ticks = 0; done_cnt = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6", int'(status), 1, "status after reset");
    chk("R1", int'(pull_low), 0, "pull_low after reset");
    chk("R1", int'(busy), 0, "busy after reset");
    chk("R3", int'(done), 0, "done after reset");

    run(0, 30, 100, 0, 0, "R5", 0);        // regular, slave present
    run(0, 100000, 0, 0, 1, "R5", 0);      // regular, no slave
    run(0, 100000, 0, 10, 3, "R4", 0);     // regular, line held low past rise check
    run(0, 30, 100, 10, 3, "R4", 0);       // error wins over presence
    run(0, 100000, 0, 4, 1, "R4", 0);      // short low before rise check: no error
    run(0, 74, 20, 0, 0, "R5", 0);         // first seen at last window tick
    run(0, 75, 100, 0, 1, "R5", 0);        // starts one tick after window: ignored
    run(1, 3, 10, 0, 0, "R5", 0);          // overdrive, present
    run(1, 100000, 0, 0, 1, "R5", 0);      // overdrive, no slave
    run(1, 100000, 0, 3, 3, "R4", 0);      // overdrive, bus error
    run(1, 9, 5, 0, 0, "R5", 0);           // overdrive, seen at last window tick
    run(1, 10, 5, 0, 1, "R5", 0);          // overdrive, just after window
    run(1, 3, 10, 0, 0, "R7", 1);          // start and speed disturbed while busy

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule